// File: doc/BRIEF.md
# Solenoid Channel Diagnostic Flag Sequencer

This block decides, cycle by cycle, when the active-low diagnostic flag of one solenoid channel is pulled low. The flag is shared by four kinds of indication: fixed-width protection pulses, flyback indication during fast turn-off, a latched open-load fault, and the result of the soft-short (output-to-ground) test. The block watches the two mode inputs of the channel, strobes and level flags from the channel's protection and comparator logic, and produces one registered pull-low enable for the pad driver.

Protection indications have precedence. When a protection request arrives while an open-load indication is shown, the open-load latch is dropped, the flag is released for a blanking interval, and only then is the protection pulse emitted, so that a reader can tell the two apart. Flyback pulses are stretched to a minimum width and withheld during under-voltage. All widths and windows are counted in clock cycles and set by parameters.

Top module: `diag_flag_seq`

## Requirements
- R1: Out of reset, and while no indication is active, `flag_low` is 0 (flag released); reset takes effect immediately and clears any pulse in progress.
- R2: A `prot_evt` strobe sampled on a clock edge pulls `flag_low` high from that edge for exactly PROT_PULSE_CYC cycles.
- R3: While `prot_hold` is 1, each rising edge of `in_a` starts a new protection pulse; while `ov_hold` is 1, each entry into excitation (`in_a`=`in_b`=1 after any other combination) starts one; a rising `in_a` with neither flag set starts none.
- R4: With `uv_flag` at 1, a rising `in_a` starts a protection pulse, and `uv_flag` rising while `in_a` is 1 starts one; `uv_flag` rising while `in_a` is 0 starts none.
- R5: While `fb_active` is 1 (and `uv_flag` is 0) the flag is low; an indication shorter than FB_MIN_CYC cycles is stretched to FB_MIN_CYC cycles from its first low cycle.
- R6: While `uv_flag` is 1 no flyback indication is shown and any stretch in progress is cancelled; if `fb_active` is still 1 when `uv_flag` returns to 0, a fresh flyback indication starts there.
- R7: When `in_b` falls while `in_a` stays 1 after excitation (`in_a`=`in_b`=1 on the previous edge) and `cur_above_ol` is 0 on that edge, the flag latches low until an edge samples `in_a` at 0.
- R8: If `cur_above_ol` is 1 on the edge where `in_b` falls, no open-load indication appears, whatever its value earlier in excitation.
- R9: A protection request while the open-load latch is set clears the latch, releases the flag for PROT_BLANK_CYC cycles, then emits the PROT_PULSE_CYC protection pulse.
- R10: Entry into soft-short mode (`in_a`=0, `in_b`=1 after both 0) starts a window; on the SS_EVAL_CYC-th edge after the entry edge, `ss_fault` is sampled and if 1 the flag latches low until `in_a` or `in_b` changes; a mode change during the window abandons the test with no indication.
- R11: A protection request arriving while a protection pulse or blanking interval is running is ignored and does not lengthen the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_a | input | 1 | Channel mode input A (level) |
| in_b | input | 1 | Channel mode input B (level) |
| prot_evt | input | 1 | One-cycle strobe: a protection condition was just detected |
| prot_hold | input | 1 | Latched protection condition (current trip or over-temperature) still present |
| ov_hold | input | 1 | Supply over-voltage condition present |
| uv_flag | input | 1 | Supply under-voltage condition present |
| fb_active | input | 1 | Output is in the flyback clamp window |
| cur_above_ol | input | 1 | Load current is above the open-load threshold |
| ss_fault | input | 1 | Output is more than the detect voltage below supply |
| flag_low | output | 1 | 1 = pull the diagnostic flag low, 0 = release it |

## Verification
The bench builds the block with a 4-cycle protection pulse, 3-cycle blanking, a 5-cycle flyback minimum and a 6-cycle soft-short window, in place of the microsecond and millisecond defaults. These small values put every pulse end, stretch boundary, blanking gap and soft-short evaluation edge a handful of cycles away, so each can be checked cycle-exactly, including a flyback longer than its minimum and a blanked protection pulse following an open-load latch.

// File: rtl/diag_seq_pkg.sv
package diag_seq_pkg;

    typedef enum logic [1:0] {
        PR_IDLE  = 2'd0,
        PR_BLANK = 2'd1,
        PR_PULSE = 2'd2
    } prot_state_e;

    function automatic int unsigned max2(input int unsigned x, input int unsigned y);
        return (x > y) ? x : y;
    endfunction

endpackage

// File: rtl/diag_prot.sv
// Protection pulse generator with blanking in front when an open-load
// indication must first be withdrawn.
module diag_prot
    import diag_seq_pkg::*;
#(
    parameter int unsigned PULSE_CYC = 750,
    parameter int unsigned BLANK_CYC = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic ol_busy,
    output logic pulse_low,
    output logic blank_on,
    output logic kill_ol
);
    localparam int unsigned CNT_MAX = max2(PULSE_CYC, BLANK_CYC);
    localparam int unsigned CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_CYC);
    localparam logic [CW-1:0] BLANK_LD = CW'(BLANK_CYC);
    localparam logic [CW-1:0] ONE      = CW'(1);

    typedef struct packed {
        prot_state_e    st;
        logic [CW-1:0]  cnt;
    } prot_regs_t;

    prot_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        kill_ol = 1'b0;
        case (r_q.st)
            PR_IDLE: begin
                if (req) begin
                    if (ol_busy) begin
                        r_d.st  = PR_BLANK;
                        r_d.cnt = BLANK_LD;
                        kill_ol = 1'b1;
                    end else begin
                        r_d.st  = PR_PULSE;
                        r_d.cnt = PULSE_LD;
                    end
                end
            end
            PR_BLANK: begin
                if (r_q.cnt <= ONE) begin
                    r_d.st  = PR_PULSE;
                    r_d.cnt = PULSE_LD;
                end else begin
                    r_d.cnt = r_q.cnt - ONE;
                end
            end
            PR_PULSE: begin
                if (r_q.cnt <= ONE) begin
                    r_d.st  = PR_IDLE;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt - ONE;
                end
            end
            default: begin
                r_d.st  = PR_IDLE;
                r_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= PR_IDLE;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pulse_low = (r_q.st == PR_PULSE);
    assign blank_on  = (r_q.st == PR_BLANK);

    // R9: the end of a blanking gap is always followed by the pulse
    p_blank_to_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blank_on) |-> pulse_low);

    // R11: a request during a running pulse does not reload it
    p_no_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_low && req && r_q.cnt > ONE) |=> (r_q.cnt == $past(r_q.cnt) - ONE));

endmodule

// File: rtl/diag_fb.sv
// Flyback indication: follows the flyback window, stretched to a minimum,
// suppressed during under-voltage.
module diag_fb #(
    parameter int unsigned MIN_CYC = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fb_active,
    input  logic uv_flag,
    output logic fb_low
);
    localparam int unsigned CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] MIN_LD = CW'(MIN_CYC);
    localparam logic [CW-1:0] ONE    = CW'(1);

    typedef struct packed {
        logic           elig;
        logic [CW-1:0]  cnt;
    } fb_regs_t;

    fb_regs_t r_d, r_q;
    logic     elig_now;

    always_comb begin
        elig_now  = fb_active & ~uv_flag;
        r_d       = r_q;
        r_d.elig  = elig_now;
        if (uv_flag) begin
            r_d.cnt = '0;
        end else if (elig_now && !r_q.elig) begin
            r_d.cnt = MIN_LD;
        end else if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.elig <= 1'b0;
            r_q.cnt  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign fb_low = r_q.elig | (r_q.cnt != '0);

    // R6: under-voltage removes the flyback indication on the next edge
    p_uv_blocks_fb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |=> !fb_low);

    // R5: an active flyback window is always indicated
    p_fb_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_active && !uv_flag) |=> fb_low);

endmodule

// File: rtl/diag_ol_ss.sv
// Open-load latch and soft-short test window with its result latch.
module diag_ol_ss #(
    parameter int unsigned SS_CYC = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_a,
    input  logic in_b,
    input  logic a_q,
    input  logic b_q,
    input  logic cur_above_ol,
    input  logic ss_fault,
    input  logic kill_ol,
    output logic ol_low,
    output logic ss_low
);
    localparam int unsigned CW = $clog2(SS_CYC + 1);
    localparam logic [CW-1:0] SS_LD = CW'(SS_CYC);
    localparam logic [CW-1:0] ONE   = CW'(1);

    typedef struct packed {
        logic           ol;
        logic           ss_run;
        logic           ss;
        logic [CW-1:0]  cnt;
    } olss_regs_t;

    olss_regs_t r_d, r_q;
    logic       exc_end;
    logic       mode_chg;
    logic       ss_entry;

    always_comb begin
        exc_end  = a_q & b_q & in_a & ~in_b;
        mode_chg = (in_a != a_q) | (in_b != b_q);
        ss_entry = ~in_a & in_b & ~a_q & ~b_q;
        r_d      = r_q;

        // open-load latch
        if (kill_ol || !in_a) begin
            r_d.ol = 1'b0;
        end else if (exc_end && !cur_above_ol) begin
            r_d.ol = 1'b1;
        end

        // soft-short window and result
        if (ss_entry) begin
            r_d.ss_run = 1'b1;
            r_d.ss     = 1'b0;
            r_d.cnt    = SS_LD;
        end else if (mode_chg) begin
            r_d.ss_run = 1'b0;
            r_d.ss     = 1'b0;
            r_d.cnt    = '0;
        end else if (r_q.ss_run) begin
            if (r_q.cnt <= ONE) begin
                r_d.ss_run = 1'b0;
                r_d.ss     = ss_fault;
                r_d.cnt    = '0;
            end else begin
                r_d.cnt = r_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ol     <= 1'b0;
            r_q.ss_run <= 1'b0;
            r_q.ss     <= 1'b0;
            r_q.cnt    <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ol_low = r_q.ol;
    assign ss_low = r_q.ss;

    // R8: the latch only sets when the current was low on the sampling edge
    p_ol_needs_low_cur_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ol_low) |-> $past(!cur_above_ol));

    // R7: in_a at 0 always ends the open-load indication
    p_ol_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_a |=> !ol_low);

    // R9: a protection request withdraws the open-load indication
    p_ol_kill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        kill_ol |=> !ol_low);

    // R10: outside soft-short mode no soft-short indication is shown
    p_ss_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_a || !in_b) |=> !ss_low);

endmodule

// File: rtl/diag_flag_seq.sv
// Diagnostic flag sequencer for one channel: event detection, protection
// request generation and merging of the four indication sources.
module diag_flag_seq #(
    parameter int unsigned PROT_PULSE_CYC = 750,
    parameter int unsigned PROT_BLANK_CYC = 500,
    parameter int unsigned FB_MIN_CYC     = 1250,
    parameter int unsigned SS_EVAL_CYC    = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_a,
    input  logic in_b,
    input  logic prot_evt,
    input  logic prot_hold,
    input  logic ov_hold,
    input  logic uv_flag,
    input  logic fb_active,
    input  logic cur_above_ol,
    input  logic ss_fault,
    output logic flag_low
);
    typedef struct packed {
        logic a;
        logic b;
        logic uv;
    } edge_regs_t;

    edge_regs_t r_d, r_q;
    logic rise_a;
    logic exc_enter;
    logic uv_rise;
    logic prot_req;
    logic pulse_low, blank_on, kill_ol;
    logic fb_low, ol_low, ss_low;

    always_comb begin
        r_d.a     = in_a;
        r_d.b     = in_b;
        r_d.uv    = uv_flag;
        rise_a    = in_a & ~r_q.a;
        exc_enter = in_a & in_b & ~(r_q.a & r_q.b);
        uv_rise   = uv_flag & ~r_q.uv;
        prot_req  = prot_evt
                  | (rise_a & prot_hold)
                  | (exc_enter & ov_hold)
                  | (rise_a & uv_flag)
                  | (uv_rise & in_a);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    diag_prot #(
        .PULSE_CYC (PROT_PULSE_CYC),
        .BLANK_CYC (PROT_BLANK_CYC)
    ) u_prot (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (prot_req),
        .ol_busy   (ol_low),
        .pulse_low (pulse_low),
        .blank_on  (blank_on),
        .kill_ol   (kill_ol)
    );

    diag_fb #(
        .MIN_CYC (FB_MIN_CYC)
    ) u_fb (
        .clk       (clk),
        .rst_n     (rst_n),
        .fb_active (fb_active),
        .uv_flag   (uv_flag),
        .fb_low    (fb_low)
    );

    diag_ol_ss #(
        .SS_CYC (SS_EVAL_CYC)
    ) u_olss (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_a         (in_a),
        .in_b         (in_b),
        .a_q          (r_q.a),
        .b_q          (r_q.b),
        .cur_above_ol (cur_above_ol),
        .ss_fault     (ss_fault),
        .kill_ol      (kill_ol),
        .ol_low       (ol_low),
        .ss_low       (ss_low)
    );

    assign flag_low = ~blank_on & (pulse_low | ss_low | ol_low | fb_low);

    // R2: a protection strobe seen while idle always starts a pulse
    p_evt_starts_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_evt && !pulse_low && !blank_on && !ol_low) |=> flag_low);

    // R4: under-voltage arriving with in_a low and no other trigger stays quiet
    p_uv_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_rise && !in_a && !prot_evt && !flag_low && !fb_active && !in_b
         && !r_q.b) |=> !flag_low);

endmodule

// File: tb/test_diag_flag_seq.sv
`timescale 1ns/1ps
module test_diag_flag_seq;
    localparam int PW  = 4;
    localparam int BW  = 3;
    localparam int FBM = 5;
    localparam int SSE = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_a = 1'b0, in_b = 1'b0, prot_evt = 1'b0, prot_hold = 1'b0, ov_hold = 1'b0;
    logic uv_flag = 1'b0, fb_active = 1'b0, cur_above_ol = 1'b1, ss_fault = 1'b0;
    logic flag_low;

    always #4 clk = ~clk;

    diag_flag_seq #(
        .PROT_PULSE_CYC (PW),
        .PROT_BLANK_CYC (BW),
        .FB_MIN_CYC     (FBM),
        .SS_EVAL_CYC    (SSE)
    ) i_diag_flag_seq (
        .clk (clk), .rst_n (rst_n), .in_a (in_a), .in_b (in_b),
        .prot_evt (prot_evt), .prot_hold (prot_hold), .ov_hold (ov_hold),
        .uv_flag (uv_flag), .fb_active (fb_active), .cur_above_ol (cur_above_ol),
        .ss_fault (ss_fault), .flag_low (flag_low)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // entry: [17:14] requirement, [13:10] repeat count,
    // [9:1] a b prot_evt prot_hold ov uv fb cur_ok ss_fault, [0] expected flag_low
    localparam logic [17:0] VEC [64] = '{
        {4'd1,  4'd2, 10'b000000010_0},  // R1 idle
        {4'd2,  4'd1, 10'b001000010_1},  // R2 strobe
        {4'd2,  4'd3, 10'b000000010_1},  // R2
        {4'd2,  4'd2, 10'b000000010_0},  // R2 pulse over
        {4'd11, 4'd1, 10'b001000010_1},  // R11
        {4'd11, 4'd1, 10'b001000010_1},  // R11 ignored request
        {4'd11, 4'd2, 10'b000000010_1},  // R11
        {4'd11, 4'd1, 10'b000000010_0},  // R11 not lengthened
        {4'd3,  4'd4, 10'b100100010_1},  // R3 a rise with hold
        {4'd3,  4'd1, 10'b100100010_0},  // R3
        {4'd3,  4'd1, 10'b000100010_0},  // R3
        {4'd3,  4'd4, 10'b100100010_1},  // R3 repeat
        {4'd3,  4'd1, 10'b000000010_0},  // R3
        {4'd3,  4'd1, 10'b100000010_0},  // R3 no hold, no pulse
        {4'd3,  4'd1, 10'b000000010_0},  // R3
        {4'd3,  4'd4, 10'b110010010_1},  // R3 excitation entry with ov
        {4'd3,  4'd1, 10'b110000010_0},  // R3
        {4'd8,  4'd1, 10'b100000010_0},  // R8 b fall, current ok
        {4'd3,  4'd4, 10'b110010010_1},  // R3 re-entry with ov
        {4'd3,  4'd1, 10'b110000010_0},  // R3
        {4'd8,  4'd1, 10'b100000010_0},  // R8
        {4'd8,  4'd1, 10'b000000010_0},  // R8
        {4'd7,  4'd1, 10'b110000010_0},  // R7 excitation
        {4'd7,  4'd1, 10'b110000000_0},  // R7 current low
        {4'd7,  4'd1, 10'b100000000_1},  // R7 b fall latches
        {4'd7,  4'd2, 10'b100000010_1},  // R7 held
        {4'd7,  4'd1, 10'b000000010_0},  // R7 a low clears
        {4'd8,  4'd1, 10'b110000000_0},  // R8 intermittent open
        {4'd8,  4'd1, 10'b110000010_0},  // R8 recovered
        {4'd8,  4'd1, 10'b100000010_0},  // R8 no fault
        {4'd8,  4'd1, 10'b000000010_0},  // R8
        {4'd9,  4'd1, 10'b110000010_0},  // R9
        {4'd9,  4'd2, 10'b100000000_1},  // R9 open-load latched
        {4'd9,  4'd1, 10'b101000010_0},  // R9 protection: blank
        {4'd9,  4'd2, 10'b100000010_0},  // R9 blank
        {4'd9,  4'd4, 10'b100000010_1},  // R9 protection pulse
        {4'd9,  4'd1, 10'b100000010_0},  // R9
        {4'd9,  4'd1, 10'b000000010_0},  // R9
        {4'd4,  4'd1, 10'b000001010_0},  // R4 uv with a low
        {4'd4,  4'd4, 10'b100001010_1},  // R4 a rise in uv
        {4'd4,  4'd1, 10'b100001010_0},  // R4
        {4'd4,  4'd1, 10'b100000010_0},  // R4
        {4'd4,  4'd4, 10'b100001010_1},  // R4 uv rise with a high
        {4'd4,  4'd1, 10'b000000010_0},  // R4
        {4'd5,  4'd1, 10'b000000110_1},  // R5 short flyback
        {4'd5,  4'd4, 10'b000000010_1},  // R5 stretched
        {4'd5,  4'd1, 10'b000000010_0},  // R5
        {4'd5,  4'd8, 10'b000000110_1},  // R5 long flyback
        {4'd5,  4'd1, 10'b000000010_0},  // R5 follows end
        {4'd6,  4'd2, 10'b000001110_0},  // R6 suppressed
        {4'd6,  4'd1, 10'b000000110_1},  // R6 deferred start
        {4'd6,  4'd4, 10'b000000010_1},  // R6 stretched
        {4'd6,  4'd1, 10'b000000010_0},  // R6
        {4'd6,  4'd1, 10'b000000110_1},  // R6
        {4'd6,  4'd1, 10'b000001110_0},  // R6 uv cancels stretch
        {4'd6,  4'd1, 10'b000001010_0},  // R6
        {4'd6,  4'd1, 10'b000000010_0},  // R6
        {4'd10, 4'd6, 10'b010000011_0},  // R10 window
        {4'd10, 4'd1, 10'b010000011_1},  // R10 evaluation
        {4'd10, 4'd2, 10'b010000010_1},  // R10 held
        {4'd10, 4'd1, 10'b000000010_0},  // R10 mode change
        {4'd10, 4'd7, 10'b010000010_0},  // R10 no fault
        {4'd10, 4'd1, 10'b010000010_0},  // R10
        {4'd10, 4'd1, 10'b000000010_0}   // R10
    };

    task automatic check(input int tag, input logic exp, input string what);
        checks++;
        if (flag_low !== exp) begin
            fails++;
            $display("FAIL R%0d %s: flag_low=%b expected %b", tag, what, flag_low, exp);
        end
    endtask

    task automatic drive(input logic [8:0] v);
        {in_a, in_b, prot_evt, prot_hold, ov_hold, uv_flag, fb_active, cur_above_ol, ss_fault} = v;
    endtask

    task automatic step(input logic [8:0] v, input int tag, input logic exp, input string what);
        @(negedge clk);
        drive(v);
        @(posedge clk);
        #2;
        check(tag, exp, what);
    endtask

    initial begin
        drive(9'b000000010);
        @(posedge clk);
        #2;
        check(1, 1'b0, "during reset");       // R1
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 64; i++) begin
            for (int k = 0; k < int'(VEC[i][13:10]); k++) begin
                step(VEC[i][9:1], int'(VEC[i][17:14]), VEC[i][0], $sformatf("vector %0d/%0d", i, k));
            end
        end

        // R10: leaving soft-short mode inside the window abandons the test
        for (int k = 0; k < 3; k++) step(9'b010000011, 10, 1'b0, "window running");
        for (int k = 0; k < SSE + 3; k++) step(9'b000000011, 10, 1'b0, "aborted window");

        // R1: reset clears a pulse in progress at once
        step(9'b001000010, 2, 1'b1, "pulse before reset");
        @(negedge clk);
        drive(9'b000000010);
        rst_n = 1'b0;
        #1;
        check(1, 1'b0, "async reset");
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < PW + 1; k++) step(9'b000000010, 1, 1'b0, "after reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog: state=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule